// File: doc/BRIEF.md
# Phase-Count PWM Timer

This block is one pulse-width channel. It sets the high part and the low part of each cycle with two separate reload counts, and it does not use a period register with a compare value. A clock divider slows the reference clock into counting ticks. Each phase then lasts a programmed number of those ticks. Software sets up the channel through two 32-bit words on a small write/read port. One word holds the two phase counts. The other holds the divider, a mode selector and a run bit.

Settings that change while the channel runs are staged. The channel keeps working copies of the divider and both counts. It refreshes those copies only when a low phase ends, so every pulse on the pin has the length of one complete, consistent setting. Clearing the run bit, or choosing any mode other than pulse-width, stops the channel at once and drives the pin low.

Top module: `phase_pwm_timer`

## Requirements
- R1: A synchronous active-low reset clears both configuration words to zero and drives `pwm_out` low.
- R2: The phase-count word (`cfg_sel`=0) holds the high count in bits [31:16] and the low count in bits [15:0]. It reads back exactly as written.
- R3: The control word (`cfg_sel`=1) holds the divider D in bits [23:16], the mode in bits [25:24] and the run bit in bit 28. These fields read back as written, and every other bit reads zero.
- R4: While the run bit is 0, `pwm_out` stays low.
- R5: The channel counts only when the mode field is 2'b10. With any other mode value, `pwm_out` stays low even when the run bit is set.
- R6: A high-count field of H gives a high phase of (H+1)·(D+1) clock cycles.
- R7: A low-count field of L gives a low phase of (L+1)·(D+1) clock cycles.
- R8: When the channel starts from the stopped state, `pwm_out` first goes high exactly D+2 clock edges after the edge that stores the enabling control word. Every period begins with its high phase.
- R9: If the counts or the divider are written while the channel runs, the current low phase still finishes with the old values. The new values apply from the next high phase.
- R10: Stopping a running channel drives `pwm_out` low on the clock edge after the edge that stores the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the selected word |
| cfg_sel | input | 1 | Word select: 0 = phase counts, 1 = control |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected word (combinational) |
| pwm_out | output | 1 | Pulse-width output |

## Verification
The assertions check, on every cycle, that the pin is low one cycle after the channel becomes inactive. They also check that the pin changes only on a divider tick or on a stop, that the working divider changes only at a period boundary or at start, and that undefined control bits read zero. Some behaviours need the bench scenarios instead. These are the exact pulse lengths for each setting, the start latency, and the fact that a mid-run write leaves the current low phase unchanged and takes effect afterwards. The bench measures each of these as a run length on the pin.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int CFG_W    = 32;
    localparam int CNT_W    = 16;
    localparam int DIV_W    = 8;
    localparam int MODE_W   = 2;
    localparam int HI_LSB   = 16;
    localparam int LO_LSB   = 0;
    localparam int DIV_LSB  = 16;
    localparam int MODE_LSB = 24;
    localparam int EN_BIT   = 28;

    localparam logic [MODE_W-1:0] MODE_PWM = 2'b10;

    localparam logic [CFG_W-1:0] CTRL_MASK =
        (((CFG_W'(1) << DIV_W) - 1) << DIV_LSB) |
        (((CFG_W'(1) << MODE_W) - 1) << MODE_LSB) |
        (CFG_W'(1) << EN_BIT);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARM  = 2'd1,
        PH_HIGH = 2'd2,
        PH_LOW  = 2'd3
    } phase_e;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int DIV_W = ptmr_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == div) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == div);
endmodule

// File: rtl/ptmr_phase.sv
module ptmr_phase
    import ptmr_pkg::*;
#(
    parameter int CNT_W = ptmr_pkg::CNT_W,
    parameter int DIV_W = ptmr_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic [CNT_W-1:0] cfg_hi,
    input  logic [CNT_W-1:0] cfg_lo,
    input  logic [DIV_W-1:0] cfg_div,
    output logic [DIV_W-1:0] live_div,
    output logic             run,
    output logic             pwm
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lo;
        logic [DIV_W-1:0] div;
        logic             pwm;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d = '0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    // take a working copy of the whole setting
                    st_d.phase = PH_ARM;
                    st_d.cnt   = cfg_hi;
                    st_d.lo    = cfg_lo;
                    st_d.div   = cfg_div;
                end
                PH_ARM: begin
                    if (tick) begin
                        st_d.phase = PH_HIGH;
                        st_d.pwm   = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (st_q.cnt == '0) begin
                            st_d.phase = PH_LOW;
                            st_d.cnt   = st_q.lo;
                            st_d.pwm   = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (st_q.cnt == '0) begin
                            // period boundary: staged values become live
                            st_d.phase = PH_HIGH;
                            st_d.cnt   = cfg_hi;
                            st_d.lo    = cfg_lo;
                            st_d.div   = cfg_div;
                            st_d.pwm   = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
                default: st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_div = st_q.div;
    assign run      = (st_q.phase != PH_IDLE);
    assign pwm      = st_q.pwm;
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int CNT_W = ptmr_pkg::CNT_W,
    parameter int DIV_W = ptmr_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output logic [CNT_W-1:0]  hi,
    output logic [CNT_W-1:0]  lo,
    output logic [DIV_W-1:0]  div,
    output logic              active
);
    typedef struct packed {
        logic [CNT_W-1:0]  hi;
        logic [CNT_W-1:0]  lo;
        logic [DIV_W-1:0]  div;
        logic [MODE_W-1:0] mode;
        logic              en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (!sel) begin
                cfg_d.hi = wdata[HI_LSB +: CNT_W];
                cfg_d.lo = wdata[LO_LSB +: CNT_W];
            end else begin
                cfg_d.div  = wdata[DIV_LSB +: DIV_W];
                cfg_d.mode = wdata[MODE_LSB +: MODE_W];
                cfg_d.en   = wdata[EN_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (!sel) begin
            rdata[HI_LSB +: CNT_W] = cfg_q.hi;
            rdata[LO_LSB +: CNT_W] = cfg_q.lo;
        end else begin
            rdata[DIV_LSB +: DIV_W]   = cfg_q.div;
            rdata[MODE_LSB +: MODE_W] = cfg_q.mode;
            rdata[EN_BIT]             = cfg_q.en;
        end
    end

    assign hi     = cfg_q.hi;
    assign lo     = cfg_q.lo;
    assign div    = cfg_q.div;
    assign active = cfg_q.en && (cfg_q.mode == MODE_PWM);
endmodule

// File: rtl/phase_pwm_timer.sv
module phase_pwm_timer
    import ptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              pwm_out
);
    logic [CNT_W-1:0] cfg_hi, cfg_lo;
    logic [DIV_W-1:0] cfg_div, live_div;
    logic             active, run, tick;

    ptmr_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .hi     (cfg_hi),
        .lo     (cfg_lo),
        .div    (cfg_div),
        .active (active)
    );

    ptmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (live_div),
        .tick  (tick)
    );

    ptmr_phase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (tick),
        .cfg_hi   (cfg_hi),
        .cfg_lo   (cfg_lo),
        .cfg_div  (cfg_div),
        .live_div (live_div),
        .run      (run),
        .pwm      (pwm_out)
    );
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
    import ptmr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic             run,
    input logic             tick,
    input logic [DIV_W-1:0] live_div,
    input logic             cfg_sel,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             pwm_out
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!pwm_out && cfg_rdata == '0));

    p_ctrl_undef_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |-> ((cfg_rdata & ~CTRL_MASK) == '0));

    // covers both the run bit (R4) and the mode gate (R5)
    p_inactive_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pwm_out);

    p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> ($past(tick) && $past(active)));

    p_fall_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out) |-> ($past(tick) || !$past(active)));

    p_div_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_div) |-> ($rose(pwm_out) || !$past(run) || !$past(active)));
endmodule

bind phase_pwm_timer ptmr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .run       (run),
    .tick      (tick),
    .live_div  (live_div),
    .cfg_sel   (cfg_sel),
    .cfg_rdata (cfg_rdata),
    .pwm_out   (pwm_out)
);

// File: tb/phase_pwm_timer_test.sv
module phase_pwm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic        cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        pwm_out;

    always #2 clk = ~clk;

    phase_pwm_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pwm_out   (pwm_out)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit    lvl;
        int    len;
        string req;
    } pulse_t;

    pulse_t expq[$];
    bit     mon_en = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: measures each completed pin run after the first fall
    bit mon_on = 1'b0, prev = 1'b0, have_start = 1'b0;
    int run_len = 0;
    always @(negedge clk) begin
        if (!mon_en) begin
            mon_on = 1'b0;
        end else if (!mon_on) begin
            mon_on     = 1'b1;
            prev       = pwm_out;
            have_start = 1'b0;
            run_len    = 0;
        end else if (pwm_out == prev) begin
            run_len++;
        end else begin
            if (have_start && expq.size() > 0) begin
                pulse_t it;
                it = expq.pop_front();
                chk(it.lvl == prev, it.req, "run level", prev, it.lvl);
                chk(it.len == run_len, it.req, "run length", run_len, it.len);
            end
            if (!have_start && !pwm_out) have_start = 1'b1;
            prev    = pwm_out;
            run_len = 1;
        end
    end

    function automatic logic [31:0] ctl(input bit en, input logic [1:0] mode,
                                        input logic [7:0] div);
        return (32'(en) << 28) | (32'(mode) << 24) | (32'(div) << 16);
    endfunction

    task automatic wr(input bit sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd_check(input bit sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        chk(cfg_rdata === exp, req, "readback", cfg_rdata, exp);
    endtask

    task automatic stays_low(input int n, input string req);
        bit seen_high = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out !== 1'b0) seen_high = 1'b1;
        end
        chk(!seen_high, req, "pin held low", seen_high, 0);
    endtask

    // stop, program, start; check the start latency (R8)
    task automatic start_run(input int hi, input int lo, input int div);
        int k;
        wr(1'b1, 32'h0);
        repeat (3) @(negedge clk);
        wr(1'b0, {hi[15:0], lo[15:0]});
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 1'b1;
        cfg_wdata = ctl(1'b1, 2'b10, div[7:0]);
        @(negedge clk);
        cfg_we = 1'b0;
        k = 1;
        while (pwm_out !== 1'b1 && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk(k == div + 3, "R8", "negedges to first high", k, div + 3);
    endtask

    task automatic push_pair(input int hi, input int lo, input int div);
        pulse_t a, b;
        a.lvl = 1'b0; a.len = (lo + 1) * (div + 1); a.req = "R7";
        b.lvl = 1'b1; b.len = (hi + 1) * (div + 1); b.req = "R6";
        expq.push_back(a);
        expq.push_back(b);
    endtask

    task automatic expect_run(input int hi, input int lo, input int div, input int pairs);
        for (int i = 0; i < pairs; i++) push_pair(hi, lo, div);
        @(posedge clk);
        mon_en = 1'b1;
        while (expq.size() != 0) @(negedge clk);
        @(posedge clk);
        mon_en = 1'b0;
    endtask

    initial begin
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_sel   = 1'b0;
        cfg_wdata = 32'h0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(pwm_out === 1'b0, "R1", "pin in reset", pwm_out, 0);
        rst_n = 1'b1;
        rd_check(1'b0, 32'h0, "R1");
        rd_check(1'b1, 32'h0, "R1");

        // R2: count word readback
        wr(1'b0, 32'hA5C3_1E0F);
        rd_check(1'b0, 32'hA5C3_1E0F, "R2");
        wr(1'b0, 32'hFFFF_FFFF);
        rd_check(1'b0, 32'hFFFF_FFFF, "R2");

        // R3: control word keeps only defined fields; mode 11 also exercises R5
        wr(1'b1, 32'hFFFF_FFFF);
        rd_check(1'b1, 32'h13FF_0000, "R3");
        stays_low(20, "R5");
        wr(1'b1, 32'hEC5A_A5A5);
        rd_check(1'b1, 32'h005A_0000, "R3");

        // R4: run bit clear, PWM mode, pin stays low
        wr(1'b0, 32'h0000_0000);
        wr(1'b1, ctl(1'b0, 2'b10, 8'd0));
        stays_low(20, "R4");

        // R5: other modes with run bit set
        wr(1'b1, ctl(1'b1, 2'b01, 8'd0));
        stays_low(20, "R5");
        wr(1'b1, ctl(1'b1, 2'b00, 8'd0));
        stays_low(20, "R5");

        // R6/R7/R8 over several settings
        start_run(2, 1, 3);
        expect_run(2, 1, 3, 2);
        start_run(0, 0, 0);
        expect_run(0, 0, 0, 3);
        start_run(1, 0, 255);
        expect_run(1, 0, 255, 1);
        start_run(300, 2, 3);
        expect_run(300, 2, 3, 2);

        // R9: mid-run rewrite during a low phase is deferred
        start_run(2, 3, 1);
        push_pair(4, 1, 0);
        expq[0].len = (3 + 1) * (1 + 1);
        expq[0].req = "R9";
        expq[1].req = "R9";
        push_pair(4, 1, 0);
        @(posedge clk);
        mon_en = 1'b1;
        @(negedge clk);
        while (pwm_out !== 1'b1) @(negedge clk);
        while (pwm_out !== 1'b0) @(negedge clk);
        wr(1'b0, {16'd4, 16'd1});
        wr(1'b1, ctl(1'b1, 2'b10, 8'd0));
        while (expq.size() != 0) @(negedge clk);
        @(posedge clk);
        mon_en = 1'b0;

        // R10: stop while high
        start_run(20, 20, 0);
        @(negedge clk);
        chk(pwm_out === 1'b1, "R10", "pin high before stop", pwm_out, 1);
        wr(1'b1, 32'h0);
        @(negedge clk);
        chk(pwm_out === 1'b0, "R10", "pin low one edge after stop", pwm_out, 0);
        stays_low(20, "R10");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule